// File: doc/BRIEF.md
# SPI Slave-Select Source and Shift-Register Write Guard

This block sits beside an SPI shifter and owns the internal select level. A control bit picks where that level comes from: the external select pin, brought into the system clock domain through a two-stage synchronizer, or a level bit written by software. When software owns the select, the pin is flagged as released so it can serve as general I/O.

From the internal select, the master/slave mode, the clock phase and the shifter's busy indication, the block decides whether a CPU write to the shift register may go ahead. A write that comes at a forbidden moment produces no write enable. In slave mode such a write also sets a sticky collision flag, which stays set until the CPU clears it. In master mode, a low internal select is reported as a configuration error.

Top module: `spi_sel_guard`

## Requirements
- R1: With `sel_sw_i`=0, `ss_int_o` equals the SS pin value sampled two rising clock edges earlier. With `sel_sw_i`=1, `ss_int_o` equals `sw_level_i` in the same cycle.
- R2: `pin_free_o` is 1 exactly when `sel_sw_i` is 1.
- R3: `cfg_err_o` is 1 exactly when `master_i`=1 and `ss_int_o`=0.
- R4: In master mode, `sr_wr_en_o` = `wr_stb_i` and not `xfer_active_i`. A master write never sets the collision flag.
- R5: In slave mode with `cpha_i`=1, a write while `xfer_active_i`=0 is accepted even if `ss_int_o` is low. This covers a software level held at 0 for a single slave. A write while `xfer_active_i`=1 is refused.
- R6: In slave mode with `cpha_i`=0, a write is accepted only when `xfer_active_i`=0 and the select is either high now or has been high since the last byte started. Any other write is refused.
- R7: A byte start is a rising edge of `xfer_active_i`. It clears the "select was high" record on the next edge. Any cycle with `ss_int_o`=1 and no start sets the record again. The record is 1 after reset.
- R8: A refused slave-mode write sets `coll_flag_o` on the next clock edge. A refused write never asserts `sr_wr_en_o`, so the shift register is left unchanged. The flag holds until `coll_clr_i`. When a set and `coll_clr_i` fall in the same cycle, the clear wins.
- R9: Synchronous reset sets both synchronizer stages to 1, sets the record to 1, and clears the flag and the stored busy state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ss_pin_i | input | 1 | External select pin (asynchronous) |
| sel_sw_i | input | 1 | 1: software level drives the select |
| sw_level_i | input | 1 | Software select level |
| master_i | input | 1 | 1: master mode |
| cpha_i | input | 1 | Clock phase bit |
| xfer_active_i | input | 1 | Shifter is moving a byte |
| wr_stb_i | input | 1 | CPU write to the shift register |
| coll_clr_i | input | 1 | Clears the collision flag |
| ss_int_o | output | 1 | Internal select level |
| sr_wr_en_o | output | 1 | Shift-register load enable |
| coll_flag_o | output | 1 | Sticky write-collision flag |
| pin_free_o | output | 1 | Select pin released for general I/O |
| cfg_err_o | output | 1 | Master mode with select low |

## Verification
The write decision is tried in all three modes with writes placed inside a byte, right after a byte while the select is still low, and after the select has pulsed high. The placement after a byte with the select still low is the one that separates phase 0 from phase 1. Pin toggles with hardware select in force show the two-cycle synchronizer delay. Toggles of the software level show the same-cycle software path. Collision clears are issued alone and on the same cycle as a new refused write, which shows the clear-over-set priority. A byte start with the select held low shows that the record of a high select is cleared one edge after the start.

// File: rtl/spi_sel_pkg.sv
package spi_sel_pkg;

    typedef enum logic [1:0] {
        WMODE_MASTER = 2'd0,
        WMODE_SLV_P0 = 2'd1,
        WMODE_SLV_P1 = 2'd2
    } wr_mode_e;

    typedef struct packed {
        logic master;
        logic cpha;
        logic sw_sel;
        logic sw_level;
    } sel_cfg_t;

    function automatic wr_mode_e mode_of(input sel_cfg_t cfg);
        if (cfg.master)
            return WMODE_MASTER;
        else if (cfg.cpha)
            return WMODE_SLV_P1;
        else
            return WMODE_SLV_P0;
    endfunction

endpackage

// File: rtl/ss_pin_sync.sv
module ss_pin_sync #(
    parameter int STAGES  = 2,
    parameter bit IDLE_LV = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= IDLE_LV;
                else     chain_q <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= {STAGES{IDLE_LV}};
                else     chain_q <= {chain_q[LAST-1:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[LAST];
endmodule

// File: rtl/sr_write_guard.sv
module sr_write_guard
    import spi_sel_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  wr_mode_e mode_i,
    input  logic     ss_int_i,
    input  logic     busy_i,
    input  logic     stb_i,
    input  logic     clr_i,
    output logic     wr_en_o,
    output logic     coll_o
);
    logic busy_d;
    logic high_seen_q;
    logic coll_q;
    logic byte_start;
    logic legal;
    logic refuse_slv;

    assign byte_start = busy_i & ~busy_d;

    always_comb begin
        unique case (mode_i)
            WMODE_MASTER: legal = ~busy_i;
            WMODE_SLV_P1: legal = ~busy_i;
            WMODE_SLV_P0: legal = ~busy_i & (ss_int_i | high_seen_q);
            default:      legal = 1'b0;
        endcase
    end

    assign wr_en_o    = stb_i & legal;
    assign refuse_slv = stb_i & ~legal & (mode_i != WMODE_MASTER);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_d      <= 1'b0;
            high_seen_q <= 1'b1;
            coll_q      <= 1'b0;
        end else begin
            busy_d <= busy_i;
            if (byte_start)
                high_seen_q <= 1'b0;
            else if (ss_int_i)
                high_seen_q <= 1'b1;
            if (clr_i)
                coll_q <= 1'b0;
            else if (refuse_slv)
                coll_q <= 1'b1;
        end
    end

    assign coll_o = coll_q;
endmodule

// File: rtl/spi_sel_guard.sv
module spi_sel_guard
    import spi_sel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ss_pin_i,
    input  logic sel_sw_i,
    input  logic sw_level_i,
    input  logic master_i,
    input  logic cpha_i,
    input  logic xfer_active_i,
    input  logic wr_stb_i,
    input  logic coll_clr_i,
    output logic ss_int_o,
    output logic sr_wr_en_o,
    output logic coll_flag_o,
    output logic pin_free_o,
    output logic cfg_err_o
);
    sel_cfg_t cfg;
    wr_mode_e mode;
    logic     pin_sync;

    assign cfg  = '{master: master_i, cpha: cpha_i, sw_sel: sel_sw_i, sw_level: sw_level_i};
    assign mode = mode_of(cfg);

    ss_pin_sync #(.STAGES(SYNC_STAGES), .IDLE_LV(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (ss_pin_i),
        .q_o (pin_sync)
    );

    assign ss_int_o   = cfg.sw_sel ? cfg.sw_level : pin_sync;
    assign pin_free_o = cfg.sw_sel;
    assign cfg_err_o  = cfg.master & ~ss_int_o;

    sr_write_guard u_guard (
        .clk     (clk),
        .rst     (rst),
        .mode_i  (mode),
        .ss_int_i(ss_int_o),
        .busy_i  (xfer_active_i),
        .stb_i   (wr_stb_i),
        .clr_i   (coll_clr_i),
        .wr_en_o (sr_wr_en_o),
        .coll_o  (coll_flag_o)
    );
endmodule

// File: rtl/spi_sel_guard_chk.sv
module spi_sel_guard_chk (
    input logic clk,
    input logic rst,
    input logic master_i,
    input logic cpha_i,
    input logic xfer_active_i,
    input logic wr_stb_i,
    input logic coll_clr_i,
    input logic sr_wr_en_o,
    input logic coll_flag_o
);
    // R8
    coll_hold_chk: assert property (@(posedge clk) disable iff (rst)
        coll_flag_o && !coll_clr_i |=> coll_flag_o);

    // R8
    clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
        coll_clr_i |=> !coll_flag_o);

    // R8
    refuse_sets_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb_i && !sr_wr_en_o && !master_i && !coll_clr_i |=> coll_flag_o);

    // R4
    master_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        master_i && !coll_flag_o |=> !coll_flag_o);

    // R6
    busy_block_chk: assert property (@(posedge clk) disable iff (rst)
        sr_wr_en_o |-> wr_stb_i && !xfer_active_i);

    // R5
    ph1_accept_chk: assert property (@(posedge clk) disable iff (rst)
        !master_i && cpha_i && wr_stb_i && !xfer_active_i |-> sr_wr_en_o);
endmodule

bind spi_sel_guard spi_sel_guard_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .master_i     (master_i),
    .cpha_i       (cpha_i),
    .xfer_active_i(xfer_active_i),
    .wr_stb_i     (wr_stb_i),
    .coll_clr_i   (coll_clr_i),
    .sr_wr_en_o   (sr_wr_en_o),
    .coll_flag_o  (coll_flag_o)
);

// File: tb/spi_sel_guard_tb_top.sv
module spi_sel_guard_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst, ss_pin, sel_sw, sw_level, master, cpha, active, stb, clr;
    logic ss_int, wr_en, coll, pin_free, cfg_err;

    int vectors = 0;
    int miscompares = 0;

    // behavioural model state
    bit   m_meta, m_sync, m_seen, m_flag, m_busy_prev;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_sel_guard dut_i (
        .clk(clk), .rst(rst), .ss_pin_i(ss_pin), .sel_sw_i(sel_sw),
        .sw_level_i(sw_level), .master_i(master), .cpha_i(cpha),
        .xfer_active_i(active), .wr_stb_i(stb), .coll_clr_i(clr),
        .ss_int_o(ss_int), .sr_wr_en_o(wr_en), .coll_flag_o(coll),
        .pin_free_o(pin_free), .cfg_err_o(cfg_err)
    );

    task automatic cmp(input string req, input logic act, input bit exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
        end
    endtask

    task automatic step(input bit r, input bit pin, input bit sw, input bit lvl,
                        input bit mst, input bit ph, input bit act, input bit s,
                        input bit c);
        bit e_ss, e_ok, e_wr, start;
        string wreq;
        @(negedge clk);
        rst = r; ss_pin = pin; sel_sw = sw; sw_level = lvl; master = mst;
        cpha = ph; active = act; stb = s; clr = c;
        #1;
        e_ss = sw ? lvl : m_sync;
        if (mst)       begin e_ok = !act;                   wreq = "R4"; end
        else if (ph)   begin e_ok = !act;                   wreq = "R5"; end
        else           begin e_ok = !act && (e_ss || m_seen); wreq = "R6"; end
        e_wr = s && e_ok;
        if (!r) begin
            cmp("R1", ss_int, e_ss);
            cmp("R2", pin_free, sw);
            cmp("R3", cfg_err, mst && !e_ss);
            cmp(wreq, wr_en, e_wr);
        end
        cmp(r ? "R9" : "R8", coll, m_flag);
        @(posedge clk);
        if (r) begin
            m_meta = 1; m_sync = 1; m_seen = 1; m_flag = 0; m_busy_prev = 0;
        end else begin
            start = act && !m_busy_prev;
            if (start) m_seen = 0;          // R7
            else if (e_ss) m_seen = 1;
            if (c) m_flag = 0;
            else if (s && !e_ok && !mst) m_flag = 1;
            m_busy_prev = act;
            m_sync = m_meta;
            m_meta = pin;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        m_meta = 1; m_sync = 1; m_seen = 1; m_flag = 0; m_busy_prev = 0;
        // R9 reset
        step(1,0,0,0,0,0,0,0,0); step(1,0,0,0,0,0,0,0,0);
        // R9 reset state visible through ports: select high, no flag
        step(0,0,0,0,0,0,0,0,0);
        // R1 pin path with two-edge delay
        step(0,0,0,0,0,0,0,0,0); step(0,1,0,0,0,0,0,0,0);
        step(0,1,0,0,0,0,0,0,0); step(0,0,0,0,0,0,0,0,0);
        step(0,0,0,0,0,0,0,0,0); step(0,0,0,0,0,0,0,0,0);
        // R1/R2 software level path
        step(0,0,1,1,0,0,0,0,0); step(0,0,1,0,0,0,0,0,0); step(0,1,1,1,0,0,0,0,0);
        // R3/R4 master: select high, writes idle and busy
        step(0,1,1,1,1,0,0,1,0); step(0,1,1,1,1,0,1,1,0); step(0,1,1,1,1,0,0,0,0);
        step(0,1,1,0,1,0,1,1,0); step(0,1,1,0,1,0,0,0,0);
        // R5 slave phase 1, software level 0 (single slave)
        step(0,1,1,0,0,1,1,0,0); step(0,1,1,0,0,1,1,1,0); step(0,1,1,0,0,1,0,1,0);
        step(0,1,1,0,0,1,1,0,0); step(0,1,1,0,0,1,0,1,1); step(0,1,1,0,0,1,0,0,0);
        // R6/R7 slave phase 0: select low through a byte, write after collides
        step(0,1,1,0,0,0,1,0,0); step(0,1,1,0,0,0,1,0,0); step(0,1,1,0,0,0,0,1,0);
        step(0,1,1,0,0,0,0,0,0);
        // R8 clear alone, then clear with a refused write in the same cycle
        step(0,1,1,0,0,0,0,0,1); step(0,1,1,0,0,0,0,1,1); step(0,1,1,0,0,0,0,0,0);
        // R7 select pulses high, then low: write accepted
        step(0,1,1,1,0,0,0,0,0); step(0,1,1,0,0,0,0,1,0); step(0,1,1,0,0,0,0,0,0);
        // R6 write during byte with select low collides
        step(0,1,1,0,0,0,1,1,0); step(0,1,1,0,0,0,0,0,1);
        // R6 hardware select via pin, phase 0
        step(0,1,0,0,0,0,0,0,0); step(0,1,0,0,0,0,0,0,0); step(0,0,0,0,0,0,0,0,0);
        step(0,0,0,0,0,0,0,1,0); step(0,0,0,0,0,0,1,0,0); step(0,0,0,0,0,0,0,1,0);
        step(0,1,0,0,0,0,0,0,1); step(0,1,0,0,0,0,0,0,0); step(0,1,0,0,0,0,0,1,0);
        step(0,0,0,0,0,0,0,0,0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule